// File: doc/BRIEF.md
# Outbound Window and Inbound Route Decoder

This block sorts CPU-side addresses into thirty-two equal outbound windows placed at the top of a 32-bit address space. By default each window is 8 MiB and the set begins at 0xF000_0000. A CPU access that lands in an enabled window is passed to the downstream PCI port. The block reports this as a one-cycle hit strobe together with the window number. Two things gate forwarding. The first is a per-window enable register. The second is a two-bit mode field in a control register, which enables forwarding as a whole only at one exact value. The two windows at the ends of the span can never forward.

The same block also routes addresses from bus masters on the PCI side. Each such address is given one of four codes: system memory, back into PCI memory, the CPU region, or no route. Both registers are loaded through a simple write port. Results are registered, so each result appears one clock after the request is sampled.

Top module: `wn_window_decoder`

## Requirements
- R1: On a hit, `fwd_win` equals the window index i, where the address lies in 0xF000_0000 + i × 0x80_0000 up to the next window base. Bits [27:23] of the address select the window.
- R2: Windows 0 and 31 never produce a hit. This holds whatever value bits 0 and 31 of the enable register hold.
- R3: A hit is possible only while control bits [8:7] equal 2'b01. With the values 2'b00, 2'b10 or 2'b11 no window forwards. The other control bits have no effect.
- R4: A hit needs `cpu_valid` high, an address at or above 0xF000_0000, and the enable bit of the address's window set. Addresses below 0xF000_0000 never hit.
- R5: A bus-master address below 0xF080_0000 is given route code 2'b01 (system memory).
- R6: A bus-master address from 0xF080_0000 through 0xFF7F_FFFF is given route code 2'b10 (PCI memory).
- R7: A bus-master address from 0xFFF0_0000 through 0xFFFF_FFFF is given route code 2'b11 (CPU region).
- R8: A bus-master address from 0xFF80_0000 through 0xFFEF_FFFF is given route code 2'b00 (no route).
- R9: `fwd_hit`/`fwd_win` and `bm_route_vld`/`bm_route` appear one clock after `cpu_valid`/`bm_valid` is sampled. A write takes `reg_sel`=0 for the enable register and `reg_sel`=1 for the control register. A request sampled on the same edge as a write is decoded with the old register values. The new values apply from the next edge.
- R10: After reset the enable and control registers are zero and no strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = window enable register, 1 = control register |
| reg_wdata | input | 32 | Write data |
| cpu_valid | input | 1 | CPU-side address valid |
| cpu_addr | input | 32 | CPU-side address |
| bm_valid | input | 1 | Bus-master address valid |
| bm_addr | input | 32 | Bus-master address |
| fwd_hit | output | 1 | Forward strobe, one clock after the request |
| fwd_win | output | 5 | Index of the window that was hit |
| bm_route_vld | output | 1 | Route result valid |
| bm_route | output | 2 | Route code |

## Verification
The bench builds the block with its default parameters: 32 windows of 8 MiB from 0xF000_0000, the CPU region from 0xFFF0_0000, the mode field at bits [8:7] with the value 2'b01, and registered outputs. With these values the bench can reach every window boundary, both suppressed end windows, and the gap between the last forwarding window and the CPU region. All four mode values can be exercised, and a write can be made to collide with a request on the same edge.

// File: rtl/wn_pkg.sv
package wn_pkg;

   // Route codes for bus-master addresses
   typedef enum logic [1:0] {
      ROUTE_NONE = 2'b00,
      ROUTE_SYS  = 2'b01,
      ROUTE_PCI  = 2'b10,
      ROUTE_CPU  = 2'b11
   } route_e;

   // Register select encoding on the write port
   localparam logic SEL_ENABLE  = 1'b0;
   localparam logic SEL_CONTROL = 1'b1;

endpackage

// File: rtl/wn_cfg_regs.sv
module wn_cfg_regs #(
   parameter int DATA_W   = 32,
   parameter int NUM_WIN  = 32,
   parameter int MODE_LSB = 7,
   parameter int MODE_W   = 2,
   parameter logic [MODE_W-1:0] MODE_VAL = 2'b01
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic               sel,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_WIN-1:0] win_en,
   output logic               fwd_active
);
   import wn_pkg::*;

   // The first and last windows are never forwarded: build a constant mask
   logic [NUM_WIN-1:0] keep_mask;
   for (genvar g = 0; g < NUM_WIN; g++) begin : g_mask
      if (g == 0 || g == NUM_WIN-1) begin : g_drop
         assign keep_mask[g] = 1'b0;
      end else begin : g_keep
         assign keep_mask[g] = 1'b1;
      end
   end

   logic [NUM_WIN-1:0] en_q;
   logic [MODE_W-1:0]  mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mode_q <= '0;
      end else if (wr) begin
         if (sel == SEL_ENABLE) en_q   <= wdata[NUM_WIN-1:0] & keep_mask;
         else                   mode_q <= wdata[MODE_LSB +: MODE_W];
      end
   end

   assign win_en     = en_q;
   assign fwd_active = (mode_q == MODE_VAL);

   // Bits of the write word outside both fields are not stored
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   // R9: an enable write lands on the next edge
   p_enable_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == SEL_ENABLE) |=> win_en[NUM_WIN-2:1] == $past(wdata[NUM_WIN-2:1]));

   // R9: without a write the configuration holds
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(win_en) && $stable(fwd_active)));

endmodule

// File: rtl/wn_fwd_decode.sv
module wn_fwd_decode #(
   parameter int ADDR_W    = 32,
   parameter int NUM_WIN   = 32,
   parameter int WIN_SHIFT = 23,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000
) (
   input  logic                       valid,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [NUM_WIN-1:0]         win_en,
   input  logic                       fwd_active,
   output logic                       hit,
   output logic [$clog2(NUM_WIN)-1:0] win
);
   localparam int IDX_W = $clog2(NUM_WIN);
   localparam int TOP_L = WIN_SHIFT + IDX_W;

   logic             in_region;
   logic [IDX_W-1:0] idx;

   assign in_region = (addr[ADDR_W-1:TOP_L] == WIN_BASE[ADDR_W-1:TOP_L]);
   assign idx       = addr[TOP_L-1:WIN_SHIFT];

   always_comb begin
      hit = valid && fwd_active && in_region && win_en[idx];
      win = idx;
   end

   // Offset bits inside a window play no part in the decision
   logic unused_offset;
   assign unused_offset = ^addr[WIN_SHIFT-1:0];

endmodule

// File: rtl/wn_inbound_route.sv
module wn_inbound_route #(
   parameter int ADDR_W    = 32,
   parameter int NUM_WIN   = 32,
   parameter int WIN_SHIFT = 23,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000,
   parameter logic [ADDR_W-1:0] CPU_LO   = 32'hFFF0_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output wn_pkg::route_e    route
);
   import wn_pkg::*;

   localparam int IDX_W = $clog2(NUM_WIN);
   localparam int TOP_L = WIN_SHIFT + IDX_W;
   localparam logic [ADDR_W-1:0] WIN_SZ  = ADDR_W'(1) << WIN_SHIFT;
   localparam logic [ADDR_W-1:0] SYS_END = WIN_BASE + WIN_SZ;

   logic             in_region;
   logic [IDX_W-1:0] idx;
   logic             pci_win;

   assign in_region = (addr[ADDR_W-1:TOP_L] == WIN_BASE[ADDR_W-1:TOP_L]);
   assign idx       = addr[TOP_L-1:WIN_SHIFT];
   assign pci_win   = in_region && (idx != '0) && (idx != {IDX_W{1'b1}});

   always_comb begin
      if (addr >= CPU_LO)       route = ROUTE_CPU;
      else if (pci_win)         route = ROUTE_PCI;
      else if (addr < SYS_END)  route = ROUTE_SYS;
      else                      route = ROUTE_NONE;
   end

endmodule

// File: rtl/wn_window_decoder.sv
module wn_window_decoder #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int NUM_WIN   = 32,
   parameter int WIN_SHIFT = 23,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'hF000_0000,
   parameter logic [ADDR_W-1:0] CPU_LO   = 32'hFFF0_0000,
   parameter int MODE_LSB  = 7,
   parameter int MODE_W    = 2,
   parameter logic [MODE_W-1:0] MODE_VAL = 2'b01,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              cpu_valid,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              bm_valid,
   input  logic [ADDR_W-1:0] bm_addr,
   output logic              fwd_hit,
   output logic [$clog2(NUM_WIN)-1:0] fwd_win,
   output logic              bm_route_vld,
   output logic [1:0]        bm_route
);
   import wn_pkg::*;

   localparam int IDX_W = $clog2(NUM_WIN);

   // Elaboration-time parameter checks
   if (NUM_WIN < 4 || (1 << IDX_W) != NUM_WIN) begin : g_chk_win
      $error("NUM_WIN must be a power of two of at least 4");
   end
   if (NUM_WIN > DATA_W) begin : g_chk_en
      $error("enable register narrower than the window count");
   end
   if (WIN_SHIFT + IDX_W > ADDR_W) begin : g_chk_span
      $error("window span exceeds the address width");
   end
   if (MODE_LSB + MODE_W > DATA_W) begin : g_chk_mode
      $error("mode field outside the control word");
   end

   logic               fwd_active;
   logic [NUM_WIN-1:0] win_en;
   logic               hit_c;
   logic [IDX_W-1:0]   win_c;
   route_e             route_c;

   wn_cfg_regs #(
      .DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .MODE_LSB(MODE_LSB),
      .MODE_W(MODE_W), .MODE_VAL(MODE_VAL)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .win_en(win_en), .fwd_active(fwd_active)
   );

   wn_fwd_decode #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_SHIFT(WIN_SHIFT), .WIN_BASE(WIN_BASE)
   ) u_fwd (
      .valid(cpu_valid), .addr(cpu_addr), .win_en(win_en), .fwd_active(fwd_active),
      .hit(hit_c), .win(win_c)
   );

   wn_inbound_route #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_SHIFT(WIN_SHIFT),
      .WIN_BASE(WIN_BASE), .CPU_LO(CPU_LO)
   ) u_route (
      .addr(bm_addr), .route(route_c)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fwd_hit      <= 1'b0;
            fwd_win      <= '0;
            bm_route_vld <= 1'b0;
            bm_route     <= ROUTE_NONE;
         end else begin
            fwd_hit      <= hit_c;
            fwd_win      <= win_c;
            bm_route_vld <= bm_valid;
            bm_route     <= route_c;
         end
      end

      // R2: the end windows never forward
      p_end_windows_r2: assert property (@(posedge clk) disable iff (!rst_n)
         fwd_hit |-> (fwd_win != '0 && fwd_win != {IDX_W{1'b1}}));

      // R3: a hit needs the mode field at its enabling value
      p_mode_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
         fwd_hit |-> $past(fwd_active));

      // R4: a hit needs a request and an enabled window
      p_hit_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
         fwd_hit |-> ($past(cpu_valid) && $past(win_en[cpu_addr[WIN_SHIFT +: IDX_W]])));

      // R7: CPU route code only for the top region
      p_cpu_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (bm_route_vld && bm_route == ROUTE_CPU) |-> $past(bm_addr) >= CPU_LO);

      // R9: no result without a request in the previous cycle
      p_idle_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !bm_valid |=> !bm_route_vld);
   end else begin : g_out_comb
      always_comb begin
         fwd_hit      = hit_c;
         fwd_win      = win_c;
         bm_route_vld = bm_valid;
         bm_route     = route_c;
      end
   end

endmodule

// File: tb/wn_window_decoder_bench.sv
`timescale 1ns/1ps
module wn_window_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic        cpu_valid = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        bm_valid = 1'b0;
   logic [31:0] bm_addr = '0;
   logic        fwd_hit;
   logic [4:0]  fwd_win;
   logic        bm_route_vld;
   logic [1:0]  bm_route;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [31:0] en_sh = '0;
   logic [31:0] ctl_sh = '0;

   always #10 clk = ~clk;   // 50 MHz

   wn_window_decoder u_wn_window_decoder (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .bm_valid(bm_valid), .bm_addr(bm_addr),
      .fwd_hit(fwd_hit), .fwd_win(fwd_win), .bm_route_vld(bm_route_vld), .bm_route(bm_route)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Model of the forwarding rule taken from the requirements
   function automatic logic model_hit(input logic [31:0] a);
      int i = int'(a[27:23]);
      return (a[31:28] == 4'hF) && (i >= 1) && (i <= 30) && en_sh[i] && (ctl_sh[8:7] == 2'b01);
   endfunction

   function automatic logic [1:0] model_route(input logic [31:0] a);
      if (a >= 32'hFFF0_0000) return 2'b11;
      if (a >= 32'hFF80_0000) return 2'b00;
      if (a >= 32'hF080_0000) return 2'b10;
      return 2'b01;
   endfunction

   task automatic wr_reg(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (sel) ctl_sh = d; else en_sh = d;
   endtask

   task automatic cpu_probe(input string tag, input logic [31:0] a);
      logic eh;
      eh = model_hit(a);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_addr = a;
      @(negedge clk);
      cpu_valid = 1'b0;
      check({tag, " hit"}, {31'b0, fwd_hit}, {31'b0, eh});
      if (eh) check({tag, " win"}, {27'b0, fwd_win}, {27'b0, a[27:23]});
   endtask

   task automatic bm_probe(input string tag, input logic [31:0] a);
      @(negedge clk);
      bm_valid = 1'b1; bm_addr = a;
      @(negedge clk);
      bm_valid = 1'b0;
      check({tag, " vld"}, {31'b0, bm_route_vld}, 32'd1);
      check({tag, " code"}, {30'b0, bm_route}, {30'b0, model_route(a)});
   endtask

   task automatic t_reset();
      check("R10 fwd_hit after reset", {31'b0, fwd_hit}, 32'd0);
      check("R10 route_vld after reset", {31'b0, bm_route_vld}, 32'd0);
      cpu_probe("R10 no forward with zero registers", 32'hF080_0000);
   endtask

   task automatic t_windows();
      wr_reg(1'b1, 32'h0000_0080);
      wr_reg(1'b0, 32'hFFFF_FFFF);
      cpu_probe("R1 window 1 base", 32'hF080_0000);
      cpu_probe("R1 window 30 base", 32'hFF00_0000);
      cpu_probe("R1 window 30 last byte", 32'hFF7F_FFFF);
      cpu_probe("R1 window 17 middle", 32'hF8AB_CDEF);
      cpu_probe("R2 window 0", 32'hF000_0000);
      cpu_probe("R2 window 31", 32'hFF80_0000);
      cpu_probe("R2 window 31 top", 32'hFFFF_FFFF);
      cpu_probe("R4 below region", 32'hEFFF_FFFF);
   endtask

   task automatic t_enables();
      wr_reg(1'b0, 32'h8000_0021);   // bits 31, 5, 0
      cpu_probe("R4 enabled window 5", 32'hF280_0000);
      cpu_probe("R4 disabled window 6", 32'hF300_0000);
      cpu_probe("R2 window 0 with bit 0 set", 32'hF040_0000);
      cpu_probe("R2 window 31 with bit 31 set", 32'hFFA0_0000);
      @(negedge clk);
      cpu_valid = 1'b0; cpu_addr = 32'hF280_0000;
      @(negedge clk);
      check("R4 no hit without cpu_valid", {31'b0, fwd_hit}, 32'd0);
   endtask

   task automatic t_mode();
      wr_reg(1'b0, 32'h7FFF_FFFE);
      wr_reg(1'b1, 32'h0000_0000);
      cpu_probe("R3 mode 00", 32'hF400_0000);
      wr_reg(1'b1, 32'h0000_0100);
      cpu_probe("R3 mode 10", 32'hF400_0000);
      wr_reg(1'b1, 32'h0000_0180);
      cpu_probe("R3 mode 11", 32'hF400_0000);
      wr_reg(1'b1, 32'hFFFF_FEFF);   // [8:7]=01 with every other bit set
      cpu_probe("R3 mode 01 other bits set", 32'hF400_0000);
   endtask

   task automatic t_timing();
      // Request on the same edge as a write that disables forwarding
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0;
      cpu_valid = 1'b1; cpu_addr = 32'hF480_0000;
      @(negedge clk);
      reg_wr = 1'b0; cpu_valid = 1'b1;
      check("R9 same-edge request uses old mode", {31'b0, fwd_hit}, 32'd1);
      check("R9 same-edge window", {27'b0, fwd_win}, 32'd9);
      ctl_sh = 32'h0;
      @(negedge clk);
      cpu_valid = 1'b0;
      check("R9 next request sees new mode", {31'b0, fwd_hit}, 32'd0);
      @(negedge clk);
      check("R9 strobe drops after request", {31'b0, fwd_hit}, 32'd0);
      check("R9 no route without request", {31'b0, bm_route_vld}, 32'd0);
   endtask

   task automatic t_routes();
      bm_probe("R5 zero", 32'h0000_0000);
      bm_probe("R5 window 0 top", 32'hF07F_FFFF);
      bm_probe("R6 span start", 32'hF080_0000);
      bm_probe("R6 span end", 32'hFF7F_FFFF);
      bm_probe("R8 gap start", 32'hFF80_0000);
      bm_probe("R8 gap end", 32'hFFEF_FFFF);
      bm_probe("R7 cpu start", 32'hFFF0_0000);
      bm_probe("R7 cpu end", 32'hFFFF_FFFF);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_windows();
      t_enables();
      t_mode();
      t_timing();
      t_routes();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule